// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a page entry by reading two levels of page tables from memory. A request carries a virtual address, a privilege flag and a read/write flag. The walker picks one of two directory roots by privilege, fetches a directory word, takes the table base from that word, and then fetches the page entry. It returns a fault, marked as a directory-level or a page-level fault, or it returns the page entry together with the memory address it was read from.

On a successful walk the walker also keeps the entry's usage flags up to date. If a write finds the dirty flag clear, it writes the entry back with both dirty and referenced set. Otherwise, if referenced is clear, it writes the entry back with referenced set. The memory port is a simple request/response channel for 32-bit words. A request stays asserted until the memory accepts it, and each access then waits for one response pulse, which also acknowledges writes. The walker takes one request at a time and holds its result until the consumer acknowledges it.

Entry word layout: bit 0 is the fault flag, bit 1 is the referenced flag and bit 2 is the dirty flag. In a directory word, bits 31:12 give the table base. Virtual address bits 31:22 are the directory index, bits 21:12 are the table index, and both are used as word offsets.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A request with `req_user`=1 walks from `usr_root`; a request with `req_user`=0 walks from `sup_root`. The root is sampled when the request is accepted.
- R3: The first memory read goes to root OR {va[31:22], 2'b00}.
- R4: If bit 0 of the directory word is 1, the result has `rsp_fault`=1 and `rsp_dir_level`=1, `rsp_addr` is the directory word's address, `rsp_entry` is the directory word, and no second read is made.
- R5: The second read goes to {dir[31:12], 12'h000} OR {va[21:12], 2'b00}. Bits 11:0 of the directory word play no part.
- R6: If bit 0 of the page entry is 1, the result has `rsp_fault`=1 and `rsp_dir_level`=0, `rsp_entry` is the raw entry, `rsp_addr` is its address, and no write is made.
- R7: For a write request whose entry has dirty (bit 2) clear, the entry is written back to its address with bits 2 and 1 set. The response carries that updated word.
- R8: Otherwise, if referenced (bit 1) is clear, the entry is written back with bit 1 set. If no flag needs to change, no write is made and the raw entry is returned.
- R9: `req_ready` is 1 only when idle. No new request is taken while a walk or an unacknowledged result is outstanding.
- R10: Once `rsp_valid` rises, it and all response fields stay unchanged until a cycle with `rsp_ready`=1, after which the walker returns to idle.
- R11: While `mem_req_valid`=1 and `mem_req_ready`=0, the memory request and its address, write enable and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_root | input | 32 | Directory root for supervisor walks |
| usr_root | input | 32 | Directory root for user walks |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 = user privilege |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_dir_level | output | 1 | Fault was found at the directory level |
| rsp_entry | output | 32 | Directory word (on a directory fault) or page entry |
| rsp_addr | output | 32 | Memory address of `rsp_entry` |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong root choice or a wrong index slice shows up on `mem_addr` at the first or second memory request. The memory model would then return a different word, so the response fields also disagree within the same walk. A flag-update error shows up as a write that should not happen, a missing write, or a wrong write value. The bench sees this in its memory image when the result arrives, so it is caught one walk later at most. Broken hold logic on either handshake shows up as changing fields during the stall and hold windows that the bench inserts on both channels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_FETCH_DIR = 3'd1,
    S_FETCH_PTE = 3'd2,
    S_WRITEBACK = 3'd3,
    S_DONE      = 3'd4
  } walk_state_e;

  localparam int ENT_W     = 32;
  localparam int BIT_FAULT = 0;
  localparam int BIT_REF   = 1;
  localparam int BIT_DIRTY = 2;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW      = 32,
  parameter int DIR_LSB = 22,
  parameter int TBL_LSB = 12
) (
  input  logic [AW-1:0]             root,
  input  logic [AW-1:0]             va,
  input  logic [ptw_pkg::ENT_W-1:0] dir_word,
  output logic [AW-1:0]             dir_addr,
  output logic [AW-1:0]             pte_addr
);
  localparam int DIR_IDX_W = AW - DIR_LSB;
  localparam int TBL_IDX_W = DIR_LSB - TBL_LSB;

  logic [AW-1:0] dir_off, tbl_off, tbl_base;

  always_comb begin
    dir_off  = '0;
    tbl_off  = '0;
    tbl_base = '0;
    dir_off[DIR_IDX_W+1:2]  = va[AW-1:DIR_LSB];
    tbl_off[TBL_IDX_W+1:2]  = va[DIR_LSB-1:TBL_LSB];
    tbl_base[AW-1:TBL_LSB]  = dir_word[AW-1:TBL_LSB];
    dir_addr = root | dir_off;
    pte_addr = tbl_base | tbl_off;
  end
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd (
  input  logic [ptw_pkg::ENT_W-1:0] entry_in,
  input  logic                      is_write,
  output logic [ptw_pkg::ENT_W-1:0] entry_out,
  output logic                      need_wb
);
  import ptw_pkg::*;

  always_comb begin
    entry_out = entry_in;
    need_wb   = 1'b0;
    if (is_write && !entry_in[BIT_DIRTY]) begin
      entry_out[BIT_DIRTY] = 1'b1;
      entry_out[BIT_REF]   = 1'b1;
      need_wb              = 1'b1;
    end else if (!entry_in[BIT_REF]) begin
      entry_out[BIT_REF] = 1'b1;
      need_wb            = 1'b1;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int AW      = 32,
  parameter int DIR_LSB = 22,
  parameter int TBL_LSB = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             sup_root,
  input  logic [AW-1:0]             usr_root,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_va,
  input  logic                      req_user,
  input  logic                      req_write,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic                      rsp_fault,
  output logic                      rsp_dir_level,
  output logic [ptw_pkg::ENT_W-1:0] rsp_entry,
  output logic [AW-1:0]             rsp_addr,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [ptw_pkg::ENT_W-1:0] mem_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [ptw_pkg::ENT_W-1:0] mem_rdata
);
  import ptw_pkg::*;

  walk_state_e       state_q, state_d;
  logic [AW-1:0]     va_q, root_q, addr_q, addr_d;
  logic              write_q, pend_q, pend_d;
  logic              fault_q, fault_d, dirl_q, dirl_d;
  logic [ENT_W-1:0]  entry_q, entry_d;
  logic              ld_req, ld_res;
  logic [AW-1:0]     dir_addr, pte_addr;
  logic [ENT_W-1:0]  upd_entry;
  logic              need_wb;
  logic              mem_fire, mem_got;

  ptw_addr_gen #(.AW(AW), .DIR_LSB(DIR_LSB), .TBL_LSB(TBL_LSB)) u_addr (
    .root     (root_q),
    .va       (va_q),
    .dir_word (entry_q),
    .dir_addr (dir_addr),
    .pte_addr (pte_addr)
  );

  ptw_flag_upd u_flags (
    .entry_in  (mem_rdata),
    .is_write  (write_q),
    .entry_out (upd_entry),
    .need_wb   (need_wb)
  );

  // memory channel
  always_comb begin
    mem_req_valid = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = addr_q;
    mem_wdata     = entry_q;
    unique case (state_q)
      S_FETCH_DIR: begin mem_req_valid = !pend_q; mem_addr = dir_addr; end
      S_FETCH_PTE: begin mem_req_valid = !pend_q; mem_addr = pte_addr; end
      S_WRITEBACK: begin mem_req_valid = !pend_q; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_fire = mem_req_valid && mem_req_ready;
  assign mem_got  = pend_q && mem_rsp_valid;

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    entry_d = entry_q;
    fault_d = fault_q;
    dirl_d  = dirl_q;
    ld_req  = 1'b0;
    ld_res  = 1'b0;
    if (mem_fire)     pend_d = 1'b1;
    else if (mem_got) pend_d = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          ld_res  = 1'b1;
          fault_d = 1'b0;
          dirl_d  = 1'b0;
          state_d = S_FETCH_DIR;
        end
      end
      S_FETCH_DIR: begin
        if (mem_got) begin
          ld_res  = 1'b1;
          entry_d = mem_rdata;
          addr_d  = dir_addr;
          if (mem_rdata[BIT_FAULT]) begin
            fault_d = 1'b1;
            dirl_d  = 1'b1;
            state_d = S_DONE;
          end else begin
            state_d = S_FETCH_PTE;
          end
        end
      end
      S_FETCH_PTE: begin
        if (mem_got) begin
          ld_res = 1'b1;
          addr_d = pte_addr;
          if (mem_rdata[BIT_FAULT]) begin
            entry_d = mem_rdata;
            fault_d = 1'b1;
            state_d = S_DONE;
          end else if (need_wb) begin
            entry_d = upd_entry;
            state_d = S_WRITEBACK;
          end else begin
            entry_d = mem_rdata;
            state_d = S_DONE;
          end
        end
      end
      S_WRITEBACK: if (mem_got) state_d = S_DONE;
      S_DONE:      if (rsp_ready) state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      root_q  <= '0;
      write_q <= 1'b0;
    end else if (ld_req) begin
      va_q    <= req_va;
      root_q  <= req_user ? usr_root : sup_root;
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      entry_q <= '0;
      fault_q <= 1'b0;
      dirl_q  <= 1'b0;
    end else if (ld_res) begin
      addr_q  <= addr_d;
      entry_q <= entry_d;
      fault_q <= fault_d;
      dirl_q  <= dirl_d;
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_DONE);
  assign rsp_fault     = fault_q;
  assign rsp_dir_level = dirl_q;
  assign rsp_entry     = entry_q;
  assign rsp_addr      = addr_q;

  // checks
  p_mreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_entry)
      && $stable(rsp_addr) && $stable(rsp_fault) && $stable(rsp_dir_level));

  p_rsp_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready);

  p_idle_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid && !pend_q);

  p_wb_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> mem_wdata[BIT_REF] && !mem_wdata[BIT_FAULT]);

  p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we && write_q |-> mem_wdata[BIT_DIRTY]);

  p_dir_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_dir_level |-> rsp_fault && rsp_entry[BIT_FAULT]);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sup_root = 32'h0001_0000;
  logic [31:0] usr_root = 32'h0002_0000;
  logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_dir_level;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_entry, rsp_addr;
  logic        mem_req_valid, mem_we;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .sup_root(sup_root), .usr_root(usr_root),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_user(req_user), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_dir_level(rsp_dir_level), .rsp_entry(rsp_entry), .rsp_addr(rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0;
  int mstall = 0, mlat = 1, hold = 0;
  logic [31:0] mem [logic [31:0]];

  typedef struct {
    logic        fault, dirl, wb;
    logic [31:0] entry, addr, wb_addr, wb_val;
  } exp_t;
  exp_t q[$];

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model; R11 stability during stall
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a0, d0;
        logic w0;
        a0 = mem_addr; w0 = mem_we; d0 = mem_wdata;
        for (int s = 0; s < mstall; s++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_addr == a0 && mem_we == w0 && mem_wdata == d0,
              "R11 request held during stall", mem_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int l = 1; l < mlat; l++) @(negedge clk);
        if (w0) mem[a0] = d0;
        mem_rdata = rd(a0);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // monitor / scoreboard; R10 hold check
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && q.size() > 0) begin
        exp_t e;
        logic [31:0] se, sa;
        e = q.pop_front();
        chk(rsp_fault == e.fault, "R4/R6 fault flag", {31'b0, rsp_fault}, {31'b0, e.fault});
        chk(rsp_dir_level == e.dirl, "R4 level flag", {31'b0, rsp_dir_level}, {31'b0, e.dirl});
        chk(rsp_entry == e.entry, "R7/R8 entry", rsp_entry, e.entry);
        chk(rsp_addr == e.addr, "R2/R3/R5 address", rsp_addr, e.addr);
        if (e.wb) chk(rd(e.wb_addr) == e.wb_val, "R7/R8 memory image", rd(e.wb_addr), e.wb_val);
        se = rsp_entry; sa = rsp_addr;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk(rsp_valid && rsp_entry == se && rsp_addr == sa, "R10 result held", rsp_entry, se);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready == 1'b1, "R10 idle after acknowledge", {31'b0, req_ready}, 32'h1);
      end
    end
  end

  // driver: computes expectation from the requirements
  task automatic walk(logic [31:0] va, logic user, logic wr, int st, int lat, int hd);
    exp_t e;
    logic [31:0] root, da, de, pa, pe, ne;
    mstall = st; mlat = lat; hold = hd;
    root = user ? usr_root : sup_root;
    da = root | {20'b0, va[31:22], 2'b00};
    de = rd(da);
    e.wb = 1'b0; e.wb_addr = '0; e.wb_val = '0;
    if (de[0]) begin
      e.fault = 1; e.dirl = 1; e.entry = de; e.addr = da;
    end else begin
      pa = {de[31:12], 12'h0} | {20'b0, va[21:12], 2'b00};
      pe = rd(pa);
      e.dirl = 0; e.addr = pa;
      if (pe[0]) begin
        e.fault = 1; e.entry = pe; e.wb = 1; e.wb_addr = pa; e.wb_val = pe;
      end else begin
        ne = pe;
        if (wr && !pe[2]) ne = ne | 32'h6;
        else if (!pe[1]) ne = ne | 32'h2;
        e.fault = 0; e.entry = ne; e.wb = 1; e.wb_addr = pa; e.wb_val = ne;
      end
    end
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_user = user; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 no accept while busy", {31'b0, req_ready}, 32'h0);
    while (q.size() != 0 || !req_ready || rsp_ready) @(negedge clk);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          fails++; checks++;
          $display("FAIL watchdog expired actual=%0d expected=0", q.size());
          $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
          $finish;
        end
      end
    join_none

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 state in reset",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 state after reset",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    mem[32'h0001_0004] = 32'h0005_0000;
    mem[32'h0005_000C] = 32'h1234_5000;   // ref clear
    mem[32'h0002_0004] = 32'h0006_0000;
    mem[32'h0006_000C] = 32'h2222_2002;   // ref set, dirty clear
    mem[32'h0001_0008] = 32'h0000_0001;   // directory fault
    mem[32'h0005_0010] = 32'hDEAD_0001;   // page fault
    mem[32'h0001_0FFC] = 32'h0007_0FFE;   // low bits must be ignored (R5)

    walk(32'h0040_3123, 0, 0, 0, 1, 0);   // R3 R5 R8 supervisor read, ref set by walker
    walk(32'h0040_3123, 1, 0, 2, 3, 2);   // R2 user root, no writeback
    walk(32'h0040_3123, 1, 1, 1, 1, 0);   // R7 write sets dirty and ref
    walk(32'h0040_3123, 1, 1, 0, 2, 3);   // R8 nothing to update
    walk(32'h0080_0000, 0, 1, 3, 1, 1);   // R4 directory fault
    walk(32'h0040_4000, 0, 1, 0, 1, 0);   // R6 page fault, no write
    walk(32'hFFFF_FFFF, 0, 0, 1, 2, 0);   // R3 R5 top index values
    walk(32'h0040_3123, 0, 1, 2, 1, 1);   // R7 write after read-only ref update
    usr_root = 32'h0001_0000;
    walk(32'h0080_0000, 1, 0, 0, 1, 0);   // R2 root sampled per request

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule